// File: doc/BRIEF.md
# Endian-Aware Read Lane Selector

This block sits between the memory read path and a processor core. Each cycle it can accept one read: either an instruction fetch or a data load. It returns the value the core should see, after steering the right bytes of the returned word into place. Memory is always allowed to return the whole word, so the selector extracts the addressed piece itself.

For fetches, a state flag picks the instruction width. When the flag is low, the instruction is the full 32-bit word. When it is high, the instruction is a 16-bit value taken from the half of the word chosen by address bit 1 and the endianness flag. For loads, the size code picks a byte, a halfword or a word. A byte or halfword is placed in the low bits and is either zero-extended or sign-extended.

The returned word can come from one of two buses. A bus-mode input chooses between the shared bidirectional data bus and a separate input-only bus. The result appears on a registered output one clock after the request.

Top module: `fetch_lane_sel`

## Requirements
- R1: `out_valid` equals `req_valid` delayed by one clock. When `req_valid` is high, `out_data` shows the result for that request after the next rising edge. Reset clears `out_valid` and `out_data` to zero.
- R2: While `req_valid` is low, `out_data` keeps its previous value, whatever the other inputs do.
- R3: A fetch (`req_fetch`=1) with `compact`=0 returns the whole 32-bit source word. On such a fetch, `size`, `addr_lo` and `sign_ext` have no effect.
- R4: A fetch with `compact`=1 and `big_end`=0 returns source bits 15:0 when `addr_lo[1]`=0 and bits 31:16 when `addr_lo[1]`=1. Bits 31:16 of the result are zero. The unselected half of the source and `sign_ext` have no effect.
- R5: A fetch with `compact`=1 and `big_end`=1 returns source bits 31:16 when `addr_lo[1]`=0 and bits 15:0 when `addr_lo[1]`=1. Bits 31:16 of the result are zero.
- R6: With `bus_uni`=1 the source word is `uni_data`, and `bidir_data` is ignored. With `bus_uni`=0 the source word is `bidir_data`, and `uni_data` is ignored.
- R7: A load (`req_fetch`=0) with `size`=2'b00 returns one byte lane. Lane k is source bits 8k+7:8k. The lane is `addr_lo` when `big_end`=0 and 3−`addr_lo` when `big_end`=1. With `sign_ext`=0, result bits 31:8 are zero.
- R8: A load with `size`=2'b01 returns the half chosen by the rules of R4/R5. With `sign_ext`=0, result bits 31:16 are zero.
- R9: With `sign_ext`=1, a byte load copies bit 7 of the extracted byte into result bits 31:8. A halfword load copies bit 15 of the extracted half into result bits 31:16.
- R10: A load with `size`=2'b10 returns the whole source word, whatever `addr_lo` is. A load with `size`=2'b11 (reserved) returns zero.
- R11: `addr_lo[0]` has no effect on halfword loads or on compact fetches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A read is presented this cycle |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data load |
| compact | input | 1 | Execution-state flag: 1 = 16-bit instructions |
| big_end | input | 1 | 1 = big-endian byte order |
| addr_lo | input | 2 | Low address bits of the read |
| size | input | 2 | Load size: 00 byte, 01 half, 10 word, 11 reserved |
| sign_ext | input | 1 | Sign-extend a byte or halfword load |
| bus_uni | input | 1 | 1 = take data from the input-only bus |
| bidir_data | input | 32 | Word from the bidirectional data bus |
| uni_data | input | 32 | Word from the input-only bus |
| out_valid | output | 1 | Result valid |
| out_data | output | 32 | Extracted, extended result |

## Verification
The assertions assume that the request fields are stable, known values whenever `req_valid` is high. They also assume that the size code, flags and both buses are sampled only in cycles where a request is presented. The bench keeps to this: it changes every input only on the falling edge, and it holds all of them at defined values from reset onward. The size and flag relations are checked only when `req_valid` is high. This keeps idle cycles with arbitrary bus contents, used to show that the output holds, outside the checked conditions.

// File: rtl/lanesel_pkg.sv
package lanesel_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 4;
  localparam int unsigned AW     = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  typedef struct packed {
    logic          fetch;
    logic          compact;
    logic          big;
    logic [AW-1:0] addr;
    xfer_size_e    size;
    logic          sext;
  } rd_req_t;
endpackage

// File: rtl/lanesel_src.sv
module lanesel_src #(
  parameter int unsigned DW = 32
) (
  input  logic          bus_uni,
  input  logic [DW-1:0] bidir_data,
  input  logic [DW-1:0] uni_data,
  output logic [DW-1:0] src_word
);
  always_comb begin
    if (bus_uni) src_word = uni_data;
    else         src_word = bidir_data;
  end
endmodule

// File: rtl/lanesel_extract.sv
module lanesel_extract
  import lanesel_pkg::*;
#(
  parameter int unsigned LW = lanesel_pkg::LANE_W,
  parameter int unsigned NL = lanesel_pkg::LANES
) (
  input  logic [LW*NL-1:0] word,
  input  rd_req_t          req,
  output logic [LW*NL-1:0] value,
  output logic             half_upper,
  output logic [AW-1:0]    byte_idx
);
  localparam int unsigned DW     = LW * NL;
  localparam int unsigned HALF_W = DW / 2;

  logic [LW-1:0]     lane_q [NL];
  logic [HALF_W-1:0] half_q [2];

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign lane_q[g] = word[g*LW +: LW];
  end
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half_q[h] = word[h*HALF_W +: HALF_W];
  end

  function automatic logic [AW-1:0] pick_byte(input logic [AW-1:0] a, input logic big);
    return big ? (AW'(NL - 1) - a) : a;
  endfunction

  function automatic logic pick_half(input logic a_hi, input logic big);
    return a_hi ^ big;
  endfunction

  function automatic logic [DW-1:0] widen_byte(input logic [LW-1:0] b, input logic sx);
    return {{(DW-LW){sx & b[LW-1]}}, b};
  endfunction

  function automatic logic [DW-1:0] widen_half(input logic [HALF_W-1:0] hv, input logic sx);
    return {{(DW-HALF_W){sx & hv[HALF_W-1]}}, hv};
  endfunction

  assign half_upper = pick_half(req.addr[AW-1], req.big);
  assign byte_idx   = pick_byte(req.addr, req.big);

  always_comb begin
    if (req.fetch) begin
      if (req.compact) value = widen_half(half_q[half_upper], 1'b0);
      else             value = word;
    end else begin
      unique case (req.size)
        SZ_BYTE: value = widen_byte(lane_q[byte_idx], req.sext);
        SZ_HALF: value = widen_half(half_q[half_upper], req.sext);
        SZ_WORD: value = word;
        default: value = '0;
      endcase
    end
  end
endmodule

// File: rtl/lanesel_oreg.sv
module lanesel_oreg #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  AST_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data)); // R2
endmodule

// File: rtl/fetch_lane_sel.sv
module fetch_lane_sel
  import lanesel_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_fetch,
  input  logic        compact,
  input  logic        big_end,
  input  logic [1:0]  addr_lo,
  input  logic [1:0]  size,
  input  logic        sign_ext,
  input  logic        bus_uni,
  input  logic [31:0] bidir_data,
  input  logic [31:0] uni_data,
  output logic        out_valid,
  output logic [31:0] out_data
);
  localparam int unsigned DW     = LANE_W * LANES;
  localparam int unsigned HALF_W = DW / 2;

  rd_req_t       req;
  logic [DW-1:0] src_word;
  logic [DW-1:0] sel_value;
  logic          half_upper;
  logic [AW-1:0] byte_idx;

  assign req = '{fetch: req_fetch, compact: compact, big: big_end,
                 addr: addr_lo, size: xfer_size_e'(size), sext: sign_ext};

  lanesel_src #(.DW(DW)) u_src (
    .bus_uni(bus_uni), .bidir_data(bidir_data), .uni_data(uni_data),
    .src_word(src_word)
  );

  lanesel_extract #(.LW(LANE_W), .NL(LANES)) u_ext (
    .word(src_word), .req(req), .value(sel_value),
    .half_upper(half_upper), .byte_idx(byte_idx)
  );

  lanesel_oreg #(.DW(DW)) u_oreg (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_data(sel_value),
    .out_valid(out_valid), .out_data(out_data)
  );

  AST_FULL_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fetch && !compact && !bus_uni) |-> (sel_value == bidir_data)); // R3
  AST_COMPACT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fetch && compact) |-> (sel_value[DW-1:HALF_W] == '0)); // R4
  AST_BE_LOW_ADDR_HIGH_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fetch && compact && big_end && !addr_lo[1])
      |-> (sel_value[HALF_W-1:0] == src_word[DW-1:HALF_W])); // R5
  AST_UNI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fetch && !compact && bus_uni) |-> (sel_value == uni_data)); // R6
  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_fetch && size == 2'b00 && !sign_ext) |-> (sel_value[DW-1:LANE_W] == '0)); // R7
  AST_BYTE_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_fetch && size == 2'b00 && sign_ext)
      |-> (sel_value[DW-1:LANE_W] == {(DW-LANE_W){sel_value[LANE_W-1]}})); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_fetch && size == 2'b11) |-> (sel_value == '0)); // R10
endmodule

// File: tb/sim_fetch_lane_sel.sv
`timescale 1ns/1ps
module sim_fetch_lane_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_fetch = 1'b0, compact = 1'b0, big_end = 1'b0;
  logic [1:0]  addr_lo = 2'b00, size = 2'b00;
  logic        sign_ext = 1'b0, bus_uni = 1'b0;
  logic [31:0] bidir_data = '0, uni_data = '0;
  logic        out_valid;
  logic [31:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fetch_lane_sel u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fetch(req_fetch),
    .compact(compact), .big_end(big_end), .addr_lo(addr_lo), .size(size),
    .sign_ext(sign_ext), .bus_uni(bus_uni), .bidir_data(bidir_data),
    .uni_data(uni_data), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [31:0] expect_val(input bit f, input bit c, input bit be,
      input logic [1:0] a, input logic [1:0] sz, input bit sx, input logic [31:0] w);
    int sh;
    logic [31:0] v;
    if (f && !c) return w;
    if (!f && sz == 2'b10) return w;
    if (!f && sz == 2'b11) return 32'h0;
    if (f || sz == 2'b01) begin
      sh = ((a[1] == 1'b1) != be) ? 16 : 0;
      v = (w >> sh) & 32'h0000_FFFF;
      if (!f && sx && v[15]) v = v | 32'hFFFF_0000;
      return v;
    end
    sh = 8 * (be ? (3 - int'(a)) : int'(a));
    v = (w >> sh) & 32'h0000_00FF;
    if (sx && v[7]) v = v | 32'hFFFF_FF00;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input bit f, input bit c, input bit be, input logic [1:0] a,
      input logic [1:0] sz, input bit sx, input bit uni,
      input logic [31:0] bd, input logic [31:0] ud);
    @(negedge clk);
    req_valid = 1'b1; req_fetch = f; compact = c; big_end = be; addr_lo = a;
    size = sz; sign_ext = sx; bus_uni = uni; bidir_data = bd; uni_data = ud;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_one(input string req, input bit f, input bit c, input bit be,
      input logic [1:0] a, input logic [1:0] sz, input bit sx, input bit uni,
      input logic [31:0] bd, input logic [31:0] ud);
    issue(f, c, be, a, sz, sx, uni, bd, ud);
    chk(req, out_data, expect_val(f, c, be, a, sz, sx, uni ? ud : bd));
  endtask

  task automatic t_reset();
    chk("R1 reset valid", {31'b0, out_valid}, 32'h0);
    chk("R1 reset data", out_data, 32'h0);
  endtask

  task automatic t_full_fetch();
    run_one("R3 full fetch", 1, 0, 0, 2'b11, 2'b00, 1, 0, 32'hCAFE_F00D, 32'h1111_2222);
    chk("R3 full fetch literal", out_data, 32'hCAFE_F00D);
    run_one("R3 full fetch big", 1, 0, 1, 2'b01, 2'b11, 0, 0, 32'h8765_4321, 32'h0);
  endtask

  task automatic t_compact_le();
    run_one("R4 le a1=0", 1, 1, 0, 2'b00, 2'b00, 1, 0, 32'hABCD_9876, 32'h0);
    chk("R4 le a1=0 literal", out_data, 32'h0000_9876);
    run_one("R4 le a1=1", 1, 1, 0, 2'b10, 2'b00, 1, 0, 32'hF234_0000, 32'h0);
    chk("R4 le a1=1 literal", out_data, 32'h0000_F234);
    run_one("R11 compact a0 ignored", 1, 1, 0, 2'b11, 2'b00, 0, 0, 32'h5A5A_C3C3, 32'h0);
    chk("R11 compact a0 literal", out_data, 32'h0000_5A5A);
  endtask

  task automatic t_compact_be();
    run_one("R5 be a1=0", 1, 1, 1, 2'b00, 2'b00, 0, 0, 32'h1357_9BDF, 32'h0);
    chk("R5 be a1=0 literal", out_data, 32'h0000_1357);
    run_one("R5 be a1=1", 1, 1, 1, 2'b10, 2'b00, 0, 0, 32'h1357_9BDF, 32'h0);
    chk("R5 be a1=1 literal", out_data, 32'h0000_9BDF);
  endtask

  task automatic t_bus_sel();
    run_one("R6 uni fetch", 1, 0, 0, 2'b00, 2'b10, 0, 1, 32'hDEAD_BEEF, 32'h0BAD_F00D);
    chk("R6 uni literal", out_data, 32'h0BAD_F00D);
    run_one("R6 uni byte", 0, 0, 0, 2'b01, 2'b00, 0, 1, 32'hFFFF_FFFF, 32'h0000_4200);
    run_one("R6 bidir ignores uni", 0, 0, 0, 2'b00, 2'b10, 0, 0, 32'h7777_0001, 32'hFFFF_FFFF);
  endtask

  task automatic t_bytes();
    for (int be = 0; be < 2; be++) begin
      for (int a = 0; a < 4; a++) begin
        run_one("R7 byte lane", 0, 0, be[0], a[1:0], 2'b00, 0, 0, 32'hF4E3_D2C1, 32'h0);
      end
    end
    run_one("R7 byte be a=0", 0, 0, 1, 2'b00, 2'b00, 0, 0, 32'hA1B2_C3D4, 32'h0);
    chk("R7 byte be a=0 literal", out_data, 32'h0000_00A1);
  endtask

  task automatic t_halves();
    for (int be = 0; be < 2; be++) begin
      for (int a = 0; a < 4; a++) begin
        run_one("R8 half load", 0, 0, be[0], a[1:0], 2'b01, 0, 0, 32'h8001_F00E, 32'h0);
      end
    end
    run_one("R11 half a0 ignored", 0, 0, 0, 2'b01, 2'b01, 0, 0, 32'h1234_5678, 32'h0);
    chk("R11 half a0 literal", out_data, 32'h0000_5678);
  endtask

  task automatic t_sign();
    run_one("R9 byte neg", 0, 0, 0, 2'b10, 2'b00, 1, 0, 32'h0080_0000, 32'h0);
    chk("R9 byte neg literal", out_data, 32'hFFFF_FF80);
    run_one("R9 byte pos", 0, 0, 0, 2'b00, 2'b00, 1, 0, 32'hFFFF_FF7F, 32'h0);
    chk("R9 byte pos literal", out_data, 32'h0000_007F);
    run_one("R9 half neg be", 0, 0, 1, 2'b00, 2'b01, 1, 0, 32'h8000_0000, 32'h0);
    chk("R9 half neg literal", out_data, 32'hFFFF_8000);
  endtask

  task automatic t_word_rsvd();
    run_one("R10 word", 0, 0, 1, 2'b11, 2'b10, 1, 0, 32'h9ABC_DEF0, 32'h0);
    chk("R10 word literal", out_data, 32'h9ABC_DEF0);
    run_one("R10 reserved", 0, 0, 0, 2'b01, 2'b11, 1, 0, 32'hFFFF_FFFF, 32'h0);
    chk("R10 reserved literal", out_data, 32'h0);
  endtask

  task automatic t_hold_latency();
    logic [31:0] prev;
    issue(1, 0, 0, 2'b00, 2'b10, 0, 0, 32'h2468_ACE0, 32'h0);
    chk("R1 valid after request", {31'b0, out_valid}, 32'h1);
    prev = out_data;
    bidir_data = 32'h1111_1111; uni_data = 32'h2222_2222; bus_uni = 1'b1;
    @(negedge clk);
    chk("R1 valid drops", {31'b0, out_valid}, 32'h0);
    chk("R2 hold data", out_data, prev);
    repeat (3) @(negedge clk);
    chk("R2 hold data later", out_data, 32'h2468_ACE0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_fetch();
    t_compact_le();
    t_compact_be();
    t_bus_sel();
    t_bytes();
    t_halves();
    t_sign();
    t_word_rsvd();
    t_hold_latency();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule